// File: doc/BRIEF.md
# Twiddle Factor Rotator with Octant-Folded Coefficient Table

This block rotates one streaming complex sample per clock by the radix-2 FFT twiddle factor W = exp(-j·2π·k/N). A sample arrives with its real part, its imaginary part, the twiddle index k and a valid strobe. The rotated sample leaves a fixed number of cycles later with a matching valid strobe. It is meant to sit between butterfly stages of a pipelined FFT, where the controller supplies k with each sample.

The cosine and sine table covers only angles from 0 to π/4, which is N/8+1 entries. An index decoder finds which eighth of the circle k falls in and folds k onto that range. A mapping step then swaps and negates the two stored values to form the coefficient for the whole circle. The four indices whose coefficient is 1, -j, -1 or +j skip the multipliers. For these, the real and imaginary parts are exchanged and negated. All paths run through the same register depth, so samples leave in the order they arrived.

Top module: `twr_twiddle_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `out_valid`, `out_re` and `out_im` all zero.
- R2: Every sample presented with `in_valid` high appears with `out_valid` high exactly 3 clock edges later. This holds for back-to-back samples, and outputs come out in input order.
- R3: For a non-trivial index, the coefficient parts are c = round(cos θ·2^14) and s = round(sin θ·2^14), with θ = 2π·k/N and k an unsigned `$clog2(N)`-bit index. The output is re = (a·c + b·s)/2^14 and im = (b·c − a·s)/2^14, where a and b are the input real and imaginary parts.
- R4: Index k = 0 returns the input sample unchanged.
- R5: Index k = N/4 gives (b, −a). Index k = N/2 gives (−a, −b). Index k = 3N/4 gives (−b, a). No multiplier is used for these.
- R6: Scaling by 2^-14 rounds half toward positive infinity. For example, 5792.5 becomes 5793 and −5792.5 becomes −5792.
- R7: Results outside the signed 16-bit range saturate to 32767 or −32768. This includes negating −32768 on the trivial paths.
- R8: Every octant, selected by the top three index bits, gives the coefficient of R3. This includes the odd-octant boundary indices k = N/8, 3N/8, 5N/8 and 7N/8, whose folded angle is exactly π/4.
- R9: A cycle with `in_valid` low gives `out_valid` low 3 edges later. Idle gaps pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| in_idx | input | $clog2(N) | Twiddle index k |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | 16 | Rotated real part, signed, saturated |
| out_im | output | 16 | Rotated imaginary part, signed, saturated |

## Verification
The checker relates outputs to inputs sampled three edges earlier, so it assumes that `in_re`, `in_im` and `in_idx` hold defined values at every edge after reset. This applies even when `in_valid` is low. It also assumes reset lasts long enough to clear the pipeline. The bench drives all inputs from the first instant and holds reset for several cycles. It changes the inputs only on falling edges and keeps the data at known values during idle cycles, so every delayed comparison refers to a defined sample.

// File: rtl/twr_pkg.sv
package twr_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Kind of rotation on the multiplier bypass, selected by octant bits [2:1]
  typedef enum logic [1:0] {
    TRV_ID   = 2'd0,   // k = 0      : multiply by 1
    TRV_NEGJ = 2'd1,   // k = N/4    : multiply by -j
    TRV_NEG  = 2'd2,   // k = N/2    : multiply by -1
    TRV_POSJ = 2'd3    // k = 3N/4   : multiply by +j
  } trv_kind_e;

  // Fixed-point quantisation with half-up rounding, used at elaboration only
  function automatic int quant(input real x, input int frac);
    return int'($floor(x * (2.0 ** frac) + 0.5));
  endfunction

endpackage

// File: rtl/twr_octant_decode.sv
module twr_octant_decode
  import twr_pkg::*;
#(
  parameter  int N  = 64,
  localparam int AW = $clog2(N),
  localparam int RW = AW - 3
) (
  input  logic [AW-1:0] idx,
  output logic [2:0]    octant,
  output logic [RW:0]   addr,
  output logic          trivial,
  output trv_kind_e     kind
);

  localparam logic [RW:0] EIGHTH = (RW+1)'(N / 8);

  logic [RW-1:0] rem;

  assign octant = idx[AW-1 -: 3];
  assign rem    = idx[RW-1:0];

  always_comb begin
    // odd octants fold backwards from pi/4 so the stored angle stays in [0, pi/4]
    if (octant[0]) addr = EIGHTH - {1'b0, rem};
    else           addr = {1'b0, rem};
    trivial = !octant[0] && (rem == '0);
    kind    = trv_kind_e'(octant[2:1]);
  end

endmodule

// File: rtl/twr_coef_rom.sv
module twr_coef_rom
  import twr_pkg::*;
#(
  parameter  int N     = 64,
  parameter  int CW    = 16,
  parameter  int FRAC  = CW - 2,
  localparam int DEPTH = N / 8 + 1,
  localparam int ABW   = $clog2(N) - 2
) (
  input  logic                 clk,
  input  logic [ABW-1:0]       addr,
  output logic signed [CW-1:0] cos_q,
  output logic signed [CW-1:0] sin_q
);

  logic signed [CW-1:0] cos_tab [DEPTH];
  logic signed [CW-1:0] sin_tab [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    localparam real ANG = TWO_PI * real'(i) / real'(N);
    assign cos_tab[i] = CW'(quant($cos(ANG), FRAC));
    assign sin_tab[i] = CW'(quant($sin(ANG), FRAC));
  end

  // registered read so the table maps onto a synchronous ROM
  always_ff @(posedge clk) begin
    cos_q <= cos_tab[addr];
    sin_q <= sin_tab[addr];
  end

endmodule

// File: rtl/twr_rotate_core.sv
module twr_rotate_core
  import twr_pkg::*;
#(
  parameter  int DW   = 16,
  parameter  int CW   = 16,
  parameter  int FRAC = CW - 2,
  localparam int PW   = DW + CW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  input  logic signed [CW-1:0] cos_q,
  input  logic signed [CW-1:0] sin_q,
  input  logic [2:0]           octant,
  input  logic                 trivial,
  input  trv_kind_e            kind,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = -(PW'(2 ** (DW - 1)));

  logic signed [CW-1:0] cr, ci;
  logic signed [PW-1:0] wa, wb, p_re, p_im, nx_re, nx_im;
  logic signed [PW-1:0] acc_re, acc_im;
  logic                 v2;

  function automatic logic signed [DW-1:0] round_sat(input logic signed [PW-1:0] x);
    logic signed [PW-1:0] r;
    r = (x + RND) >>> FRAC;
    if (r > MAXV)      return MAXV[DW-1:0];
    else if (r < MINV) return MINV[DW-1:0];
    else               return r[DW-1:0];
  endfunction

  // region mapping: build the coefficient from the folded pair
  always_comb begin
    unique case (octant)
      3'd0: begin cr =  cos_q; ci = -sin_q; end
      3'd1: begin cr =  sin_q; ci = -cos_q; end
      3'd2: begin cr = -sin_q; ci = -cos_q; end
      3'd3: begin cr = -cos_q; ci = -sin_q; end
      3'd4: begin cr = -cos_q; ci =  sin_q; end
      3'd5: begin cr = -sin_q; ci =  cos_q; end
      3'd6: begin cr =  sin_q; ci =  cos_q; end
      default: begin cr = cos_q; ci = sin_q; end
    endcase
  end

  always_comb begin
    wa   = PW'(a);
    wb   = PW'(b);
    p_re = (wa * PW'(cr)) - (wb * PW'(ci));
    p_im = (wa * PW'(ci)) + (wb * PW'(cr));
    if (trivial) begin
      unique case (kind)
        TRV_ID:   begin nx_re =  wa <<< FRAC;    nx_im =  wb <<< FRAC;    end
        TRV_NEGJ: begin nx_re =  wb <<< FRAC;    nx_im = -(wa <<< FRAC);  end
        TRV_NEG:  begin nx_re = -(wa <<< FRAC);  nx_im = -(wb <<< FRAC);  end
        default:  begin nx_re = -(wb <<< FRAC);  nx_im =  wa <<< FRAC;    end
      endcase
    end else begin
      nx_re = p_re;
      nx_im = p_im;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2        <= 1'b0;
      acc_re    <= '0;
      acc_im    <= '0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      v2        <= in_valid;
      acc_re    <= nx_re;
      acc_im    <= nx_im;
      out_valid <= v2;
      out_re    <= round_sat(acc_re);
      out_im    <= round_sat(acc_im);
    end
  end

endmodule

// File: rtl/twr_twiddle_mul.sv
module twr_twiddle_mul
  import twr_pkg::*;
#(
  parameter  int N    = 64,
  parameter  int DW   = 16,
  parameter  int CW   = 16,
  parameter  int FRAC = CW - 2,
  localparam int AW   = $clog2(N),
  localparam int RW   = AW - 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [AW-1:0]        in_idx,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);

  logic [2:0]           dec_oct, oct1;
  logic [RW:0]          dec_addr;
  logic                 dec_triv, triv1, v1;
  trv_kind_e            dec_kind, kind1;
  logic signed [DW-1:0] a1, b1;
  logic signed [CW-1:0] cos_q, sin_q;

  twr_octant_decode #(.N(N)) u_decode (
    .idx     (in_idx),
    .octant  (dec_oct),
    .addr    (dec_addr),
    .trivial (dec_triv),
    .kind    (dec_kind)
  );

  twr_coef_rom #(.N(N), .CW(CW), .FRAC(FRAC)) u_rom (
    .clk   (clk),
    .addr  (dec_addr),
    .cos_q (cos_q),
    .sin_q (sin_q)
  );

  // stage 1: align sample and decode results with the ROM read
  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      a1    <= '0;
      b1    <= '0;
      oct1  <= '0;
      triv1 <= 1'b0;
      kind1 <= TRV_ID;
    end else begin
      v1    <= in_valid;
      a1    <= in_re;
      b1    <= in_im;
      oct1  <= dec_oct;
      triv1 <= dec_triv;
      kind1 <= dec_kind;
    end
  end

  twr_rotate_core #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_core (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (v1),
    .a         (a1),
    .b         (b1),
    .cos_q     (cos_q),
    .sin_q     (sin_q),
    .octant    (oct1),
    .trivial   (triv1),
    .kind      (kind1),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
  );

endmodule

// File: rtl/twr_twiddle_mul_chk.sv
module twr_twiddle_mul_chk #(
  parameter  int N  = 64,
  parameter  int DW = 16,
  localparam int AW = $clog2(N)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_re,
  input logic signed [DW-1:0] in_im,
  input logic [AW-1:0]        in_idx,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_re,
  input logic signed [DW-1:0] out_im
);

  localparam logic [AW-1:0] IDX_QTR  = AW'(N / 4);
  localparam logic [AW-1:0] IDX_HALF = AW'(N / 2);

  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst)               seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] x);
    logic signed [DW-1:0] mn;
    mn = {1'b1, {(DW-1){1'b0}}};
    return (x == mn) ? ~mn : -x;
  endfunction

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_re == '0 && out_im == '0));

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  p_identity_r4: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(in_valid, 3) && $past(in_idx, 3) == '0)
      |-> (out_re == $past(in_re, 3) && out_im == $past(in_im, 3)));

  p_half_turn_r5: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(in_valid, 3) && $past(in_idx, 3) == IDX_HALF)
      |-> (out_re == neg_sat($past(in_re, 3)) && out_im == neg_sat($past(in_im, 3))));

  p_quarter_turn_r5: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd3 && $past(in_valid, 3) && $past(in_idx, 3) == IDX_QTR)
      |-> (out_re == $past(in_im, 3) && out_im == neg_sat($past(in_re, 3))));

endmodule

bind twr_twiddle_mul twr_twiddle_mul_chk #(.N(N), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_re     (in_re),
  .in_im     (in_im),
  .in_idx    (in_idx),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/twr_twiddle_mul_bench.sv
`timescale 1ns/1ps
module twr_twiddle_mul_bench;

  localparam int  N      = 64;
  localparam int  AW     = 6;
  localparam real TWO_PI = 6.283185307179586;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [15:0]   in_re = '0;
  logic signed [15:0]   in_im = '0;
  logic [AW-1:0]        in_idx = '0;
  logic                 out_valid;
  logic signed [15:0]   out_re, out_im;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  twr_twiddle_mul #(.N(N)) u_twr_twiddle_mul (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_re (in_re), .in_im (in_im),
    .in_idx (in_idx), .out_valid (out_valid), .out_re (out_re), .out_im (out_im)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint sat16(input longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  // reference from R3/R6/R7: quantised coefficient, half-up rounding, saturation
  task automatic model(input logic signed [15:0] a, input logic signed [15:0] b,
                       input int k, output longint er, output longint ei);
    real th;
    longint c, s, la, lb;
    th = TWO_PI * real'(k) / real'(N);
    c  = longint'($floor($cos(th) * 16384.0 + 0.5));
    s  = longint'($floor($sin(th) * 16384.0 + 0.5));
    la = a;
    lb = b;
    er = sat16((la * c + lb * s + 8192) >>> 14);
    ei = sat16((lb * c - la * s + 8192) >>> 14);
  endtask

  // one isolated sample; checks silence one cycle early and the result on time
  task automatic run_one(input logic signed [15:0] a, input logic signed [15:0] b,
                         input int k, input string tag);
    longint er, ei;
    @(negedge clk);
    in_valid = 1'b1; in_re = a; in_im = b; in_idx = AW'(k);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, {tag, " R2 early valid"}, out_valid, 0);
    @(negedge clk);
    model(a, b, k, er, ei);
    check(out_valid == 1'b1, {tag, " R2 valid"}, out_valid, 1);
    check(out_re == er, {tag, " re"}, out_re, er);
    check(out_im == ei, {tag, " im"}, out_im, ei);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    check(out_re == 0 && out_im == 0, "R1 data in reset", out_re, 0);
    rst = 1'b0;
  endtask

  task automatic t_identity();
    run_one(16'sd12345, -16'sd4321, 0, "R4 identity");
    run_one(-16'sd32768, 16'sd32767, 0, "R4 identity extremes");
  endtask

  task automatic t_trivial();
    run_one(16'sd1000, -16'sd2000, N/4, "R5 minus j");
    run_one(16'sd1000, -16'sd2000, N/2, "R5 minus one");
    run_one(16'sd1000, -16'sd2000, 3*N/4, "R5 plus j");
  endtask

  task automatic t_octants();
    for (int o = 0; o < 8; o++) begin
      run_one(16'sd12345, -16'sd6789, o*(N/8) + 3, "R8 octant interior");
      if (o % 2 == 1) run_one(-16'sd9000, 16'sd20000, o*(N/8), "R8 octant boundary");
    end
  endtask

  task automatic t_rounding();
    // k = N/8: c = s = 11585; 8192*11585/16384 = 5792.5 -> 5793, -5792.5 -> -5792
    run_one(16'sd8192, 16'sd0, N/8, "R6 half-up");
    check(out_re == 5793, "R6 positive tie", out_re, 5793);
    check(out_im == -5792, "R6 negative tie", out_im, -5792);
  endtask

  task automatic t_saturate();
    run_one(-16'sd32768, -16'sd32768, N/2, "R7 negate min");
    check(out_re == 32767 && out_im == 32767, "R7 negate min clip", out_re, 32767);
    run_one(16'sd32767, 16'sd32767, N/8, "R7 product clip");
    check(out_re == 32767, "R7 product clip high", out_re, 32767);
    run_one(-16'sd32768, 16'sd32767, 3*N/4, "R7 plus j clip");
  endtask

  task automatic t_stream();
    logic signed [15:0] sa [N];
    logic signed [15:0] sb [N];
    longint er, ei;
    for (int j = 0; j < N; j++) begin
      sa[j] = 16'((j * 1237 + 500) % 65536 - 32768);
      sb[j] = 16'((j * 4111 + 9000) % 65536 - 32768);
    end
    for (int j = 0; j < N + 3; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        model(sa[j-3], sb[j-3], j - 3, er, ei);
        check(out_valid == 1'b1, "R2 stream valid", out_valid, 1);
        check(out_re == er, "R3 stream re", out_re, er);
        check(out_im == ei, "R3 stream im", out_im, ei);
      end
      if (j < N) begin
        in_valid = 1'b1; in_re = sa[j]; in_im = sb[j]; in_idx = AW'(j);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic t_idle();
    bit [5:0] pat = 6'b011001;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 3) check(out_valid == ((j - 3) < 6 ? pat[j-3] : 1'b0), "R9 idle gaps",
                        out_valid, ((j - 3) < 6) ? pat[j-3] : 1'b0);
      in_valid = (j < 6) ? pat[j] : 1'b0;
      in_re = 16'sd77; in_im = -16'sd77; in_idx = AW'(5);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_identity();
    t_trivial();
    t_octants();
    t_rounding();
    t_saturate();
    t_stream();
    t_idle();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule